// File: doc/BRIEF.md
# Tracking Brake and Jump Masking Controller

This block sits beside a tracking loop filter and decides, cycle by cycle, what the filter sees at its input and what reaches the drive stage at its output. It does this while the pickup crosses tracks and while it is being braked. A cancel level is made by sampling the mirror level at every edge of the tracking zero-cross signal. Depending on a control bit, that cancel level blanks either the drive output or the filter input. A separate mirror mask can also blank the filter input whenever the mirror level is high.

During a surf jump the block can freeze the drive at the last sample the filter produced before the jump began. When the jump hands back to servo-on, it can raise a one-cycle request that clears the filter's state memory. Four control bits are written together through a load strobe, and all of them come out of reset at zero.

Both sample paths are valid/ready streams that pass straight through the block. Valid runs forward unchanged and ready runs backward unchanged, so back-pressure from the filter or from the drive stage reaches the source in the same cycle. A sample counts as transferred only in a cycle where valid and ready are both high. Masking changes only the data field and never the handshake.

Top module: `trk_brake_ctl`

## Requirements
- R1: After reset, every control bit is 0, the cancel level is 0, no clear request is raised, and both streams pass their data unchanged.
- R2: The tracking zero-cross input passes through a two-flop synchronizer. On each of its rising and falling edges, the cancel level takes the current mirror level. The new value first affects the outputs three clock edges after the zero-cross input changes, and it holds until the next edge.
- R3: With control bit 0 (brake_at_input) clear and the cancel level high, the drive data is 0.
- R4: With control bit 0 set and the cancel level high, the filter input data is 0 and the drive data passes through.
- R5: With control bit 1 (mirror mask) set and the mirror input high, the filter input data is 0 whatever the brake state.
- R6: With control bit 2 (surf hold) set and surf mode high, the drive follows the filter output during the cycle the jump flag rises. From the next cycle until the jump flag falls, the drive data equals the last filter-output sample accepted before the rising cycle, or 0 if no sample has been accepted since reset. A cancel level that blanks the drive takes priority over the hold.
- R7: With control bit 3 (clear on jump end) set and surf mode high, the clear request is high for exactly the single cycle in which the jump flag is first seen low after being high.
- R8: With control bit 3 clear, or with surf mode low, the fall of the jump flag raises no clear request.
- R9: fin_valid equals te_valid, te_ready equals fin_ready, drv_valid equals fout_valid and fout_ready equals drv_ready in every cycle, whatever masking is active.
- R10: When neither mask nor hold applies, the filter input data equals te_data and the drive data equals fout_data in the same cycle. This holds even when the mirror input is high while control bit 1 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_load | input | 1 | Loads ctl_wdata into the control bits |
| ctl_wdata | input | 4 | bit0 brake_at_input, bit1 mirror mask, bit2 surf hold, bit3 clear on jump end |
| mirr_i | input | 1 | Mirror level |
| tzc_i | input | 1 | Tracking zero-cross, asynchronous |
| jump_i | input | 1 | Track jump in progress |
| surf_i | input | 1 | Surf-jump mode |
| te_valid | input | 1 | Tracking error sample valid |
| te_ready | output | 1 | Tracking error sample accepted |
| te_data | input | DW | Tracking error sample |
| fin_valid | output | 1 | Filter input valid |
| fin_ready | input | 1 | Filter ready for input |
| fin_data | output | DW | Filter input sample, zero when masked |
| fout_valid | input | 1 | Filter output valid |
| fout_ready | output | 1 | Filter output accepted |
| fout_data | input | DW | Filter output sample |
| drv_valid | output | 1 | Drive sample valid |
| drv_ready | input | 1 | Drive stage ready |
| drv_data | output | DW | Drive sample after brake and hold |
| clr_req | output | 1 | One-cycle request to clear the filter state |

## Verification
The masking, pass-through and handshake results are combinational, so they are due in the same cycle as their stimulus. The bench sets inputs after a falling edge and reads the outputs one time unit later. A new cancel level is due three rising edges after tzc_i changes, and the bench waits exactly those three edges before it checks brake effects. The hold value appears one edge after the jump flag rises and drops in the cycle the flag falls. The clear request appears in the falling cycle and is gone after the next edge, and the bench samples each of these at that cycle.

// File: rtl/trk_brake_pkg.sv
package trk_brake_pkg;
  localparam int CTL_W = 4;

  typedef struct packed {
    logic clr_on_end;
    logic hold_en;
    logic mirr_mask;
    logic brake_at_input;
  } trk_ctl_t;
endpackage

// File: rtl/trk_cancel_gen.sv
module trk_cancel_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tzc_i,
  input  logic mirr_i,
  output logic cancel_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic             edge_det;
  logic             cancel_q;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= tzc_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign edge_det = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cancel_q <= 1'b0;
    else if (edge_det) cancel_q <= mirr_i;

  assign cancel_o = cancel_q;

  // R2: the cancel level moves only on a synchronized zero-cross edge
  assert_cancel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_det |=> $stable(cancel_q));
  assert_cancel_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> cancel_q == $past(mirr_i));
endmodule

// File: rtl/trk_surf_ctl.sv
module trk_surf_ctl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_en,
  input  logic          clr_on_end,
  input  logic          surf_i,
  input  logic          jump_i,
  input  logic [DW-1:0] last_acc,
  output logic          hold_active,
  output logic [DW-1:0] held_data,
  output logic          clr_req
);
  logic          jump_q;
  logic          hold_q;
  logic [DW-1:0] held_q;
  logic          jump_rise;
  logic          jump_fall;

  assign jump_rise = jump_i & ~jump_q;
  assign jump_fall = ~jump_i & jump_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      jump_q <= 1'b0;
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      jump_q <= jump_i;
      if (jump_rise && surf_i && hold_en) begin
        hold_q <= 1'b1;
        held_q <= last_acc;
      end else if (!jump_i) begin
        hold_q <= 1'b0;
      end
    end

  assign hold_active = hold_q & jump_i;
  assign held_data   = held_q;
  assign clr_req     = jump_fall & surf_i & clr_on_end;

  // R6: the frozen value never drifts while the hold lasts
  assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active && $past(hold_active) |-> $stable(held_q));
  // R7: the clear request is a single-cycle pulse
  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !clr_req);
  // R8: no request without both enables
  assert_clr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_end || !surf_i) |-> !clr_req);
endmodule

// File: rtl/trk_mask_path.sv
module trk_mask_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brake_at_input,
  input  logic          mirr_mask,
  input  logic          mirr_i,
  input  logic          cancel,
  input  logic          hold_active,
  input  logic [DW-1:0] held_data,
  input  logic          te_valid,
  output logic          te_ready,
  input  logic [DW-1:0] te_data,
  output logic          fin_valid,
  input  logic          fin_ready,
  output logic [DW-1:0] fin_data,
  input  logic          fout_valid,
  output logic          fout_ready,
  input  logic [DW-1:0] fout_data,
  output logic          drv_valid,
  input  logic          drv_ready,
  output logic [DW-1:0] drv_data,
  output logic [DW-1:0] last_acc
);
  logic          in_mask;
  logic          out_blank;
  logic [DW-1:0] last_q;

  assign in_mask   = (mirr_mask & mirr_i) | (brake_at_input & cancel);
  assign out_blank = ~brake_at_input & cancel;

  assign fin_valid = te_valid;
  assign te_ready  = fin_ready;
  assign fin_data  = in_mask ? '0 : te_data;

  assign drv_valid  = fout_valid;
  assign fout_ready = drv_ready;

  always_comb begin
    if (out_blank)        drv_data = '0;
    else if (hold_active) drv_data = held_data;
    else                  drv_data = fout_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       last_q <= '0;
    else if (fout_valid && drv_ready) last_q <= fout_data;

  assign last_acc = last_q;

  // R5: a high mirror under the mirror mask blanks the filter input
  assert_mirr_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mirr_mask && mirr_i |-> fin_data == '0);
  // R3: brake at the output blanks the drive
  assert_brake_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !brake_at_input && cancel |-> drv_data == '0);
  // R4: brake at the input leaves the drive alone
  assert_brake_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brake_at_input && cancel && !hold_active |-> drv_data == fout_data);
  // R9: the accepted-sample register only moves on a transfer
  assert_last_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fout_valid && drv_ready) |=> $stable(last_q));
endmodule

// File: rtl/trk_brake_ctl.sv
module trk_brake_ctl
  import trk_brake_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_load,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             mirr_i,
  input  logic             tzc_i,
  input  logic             jump_i,
  input  logic             surf_i,
  input  logic             te_valid,
  output logic             te_ready,
  input  logic [DW-1:0]    te_data,
  output logic             fin_valid,
  input  logic             fin_ready,
  output logic [DW-1:0]    fin_data,
  input  logic             fout_valid,
  output logic             fout_ready,
  input  logic [DW-1:0]    fout_data,
  output logic             drv_valid,
  input  logic             drv_ready,
  output logic [DW-1:0]    drv_data,
  output logic             clr_req
);
  trk_ctl_t      ctl_q;
  logic          cancel;
  logic          hold_active;
  logic [DW-1:0] held_data;
  logic [DW-1:0] last_acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ctl_q <= '0;
    else if (ctl_load) ctl_q <= trk_ctl_t'(ctl_wdata);

  trk_cancel_gen #(.SYNC_STAGES(SYNC_STAGES)) u_cancel (
    .clk(clk), .rst_n(rst_n), .tzc_i(tzc_i), .mirr_i(mirr_i), .cancel_o(cancel)
  );

  trk_surf_ctl #(.DW(DW)) u_surf (
    .clk(clk), .rst_n(rst_n),
    .hold_en(ctl_q.hold_en), .clr_on_end(ctl_q.clr_on_end),
    .surf_i(surf_i), .jump_i(jump_i), .last_acc(last_acc),
    .hold_active(hold_active), .held_data(held_data), .clr_req(clr_req)
  );

  trk_mask_path #(.DW(DW)) u_path (
    .clk(clk), .rst_n(rst_n),
    .brake_at_input(ctl_q.brake_at_input), .mirr_mask(ctl_q.mirr_mask),
    .mirr_i(mirr_i), .cancel(cancel),
    .hold_active(hold_active), .held_data(held_data),
    .te_valid(te_valid), .te_ready(te_ready), .te_data(te_data),
    .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
    .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data),
    .drv_valid(drv_valid), .drv_ready(drv_ready), .drv_data(drv_data),
    .last_acc(last_acc)
  );

  // R9: handshakes pass straight through in both directions
  assert_stream_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid == te_valid && te_ready == fin_ready &&
    drv_valid == fout_valid && fout_ready == drv_ready);
endmodule

// File: tb/trk_brake_ctl_bench.sv
module trk_brake_ctl_bench;
  localparam int DW = 16;
  localparam int VW = 4 + 1 + 4 * DW;
  localparam int NV = 8;

  // {ctl, mirr, te_data, fout_data, exp_fin, exp_drv}; cancel level is 0
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0000, 1'b0, 16'h1234, 16'hABCD, 16'h1234, 16'hABCD},
    {4'b0010, 1'b1, 16'h1234, 16'hABCD, 16'h0000, 16'hABCD},
    {4'b0010, 1'b0, 16'h5555, 16'h7777, 16'h5555, 16'h7777},
    {4'b0000, 1'b1, 16'h4321, 16'h0F0F, 16'h4321, 16'h0F0F},
    {4'b0001, 1'b1, 16'h0101, 16'h0202, 16'h0101, 16'h0202},
    {4'b0011, 1'b1, 16'h0303, 16'h0404, 16'h0000, 16'h0404},
    {4'b0100, 1'b0, 16'h0505, 16'h0606, 16'h0505, 16'h0606},
    {4'b1000, 1'b1, 16'h0707, 16'h0808, 16'h0707, 16'h0808}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_load = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic mirr_i = 1'b0, tzc_i = 1'b0, jump_i = 1'b0, surf_i = 1'b0;
  logic te_valid = 1'b0, fin_ready = 1'b0, fout_valid = 1'b0, drv_ready = 1'b0;
  logic [DW-1:0] te_data = '0, fout_data = '0;
  logic te_ready, fin_valid, fout_ready, drv_valid, clr_req;
  logic [DW-1:0] fin_data, drv_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trk_brake_ctl #(.DW(DW)) u_trk_brake_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_wdata(ctl_wdata),
    .mirr_i(mirr_i), .tzc_i(tzc_i), .jump_i(jump_i), .surf_i(surf_i),
    .te_valid(te_valid), .te_ready(te_ready), .te_data(te_data),
    .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
    .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data),
    .drv_valid(drv_valid), .drv_ready(drv_ready), .drv_data(drv_data),
    .clr_req(clr_req)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic load(input logic [3:0] w);
    ctl_wdata = w;
    ctl_load  = 1'b1;
    step();
    ctl_load  = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    te_valid = 1'b1; fin_ready = 1'b1; fout_valid = 1'b1; drv_ready = 1'b1;
    te_data = 16'h00AA; fout_data = 16'h00BB; mirr_i = 1'b1;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1: reset state, no control bit set, streams pass
    chk("R1 fin", fin_data, 16'h00AA);
    chk("R1 drv", drv_data, 16'h00BB);
    chk("R1 clr", {15'd0, clr_req}, 16'd0);

    // table of combinational cases
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][VW-1 -: 4]);
      mirr_i    = VEC[i][VW-5];
      te_data   = VEC[i][4*DW-1 -: DW];
      fout_data = VEC[i][3*DW-1 -: DW];
      #1;
      chk("R5/R10/R4 fin", fin_data, VEC[i][2*DW-1 -: DW]);
      chk("R10 drv", drv_data, VEC[i][DW-1:0]);
    end

    // R9: handshake pass-through under back-pressure
    load(4'b0011); mirr_i = 1'b1;
    te_valid = 1'b1; fin_ready = 1'b0; fout_valid = 1'b0; drv_ready = 1'b1;
    #1;
    chk("R9 te_ready", {15'd0, te_ready}, 16'd0);
    chk("R9 fin_valid", {15'd0, fin_valid}, 16'd1);
    chk("R9 drv_valid", {15'd0, drv_valid}, 16'd0);
    chk("R9 fout_ready", {15'd0, fout_ready}, 16'd1);
    fin_ready = 1'b1; fout_valid = 1'b1;

    // R2: capture mirror=1 on a rising zero-cross, brake at output
    load(4'b0000);
    mirr_i = 1'b1; te_data = 16'h1111; fout_data = 16'h2222;
    tzc_i = 1'b1;
    step(); step();
    chk("R2 not yet", drv_data, 16'h2222);
    step();
    mirr_i = 1'b0; #1;
    chk("R3 drv blanked", drv_data, 16'h0000);
    chk("R3 fin passes", fin_data, 16'h1111);
    // R4: move the brake to the input
    load(4'b0001);
    chk("R4 fin blanked", fin_data, 16'h0000);
    chk("R4 drv passes", drv_data, 16'h2222);
    // R2: falling zero-cross captures mirror=0
    tzc_i = 1'b0;
    step(); step(); step();
    chk("R2 cancel cleared fin", fin_data, 16'h1111);

    // R6: surf hold
    load(4'b0100); surf_i = 1'b1;
    fout_data = 16'h1A1A; step();
    fout_data = 16'h2B2B; jump_i = 1'b1; #1;
    chk("R6 rise passes", drv_data, 16'h2B2B);
    step();
    fout_data = 16'h3C3C; #1;
    chk("R6 held", drv_data, 16'h1A1A);
    step();
    chk("R6 still held", drv_data, 16'h1A1A);
    jump_i = 1'b0; #1;
    chk("R6 release", drv_data, 16'h3C3C);
    chk("R8 no clear with bit3 clear", {15'd0, clr_req}, 16'd0);
    step();

    // R7: clear on jump end
    load(4'b1000); jump_i = 1'b1; step();
    jump_i = 1'b0; #1;
    chk("R7 pulse", {15'd0, clr_req}, 16'd1);
    step();
    chk("R7 one cycle", {15'd0, clr_req}, 16'd0);
    // R8: surf mode low
    surf_i = 1'b0; jump_i = 1'b1; step();
    jump_i = 1'b0; #1;
    chk("R8 no pulse surf low", {15'd0, clr_req}, 16'd0);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule